// File: doc/BRIEF.md
# Multi-tap I/Q correlator channel

This block is one acquisition channel of a spread-spectrum receiver. It takes 2-bit samples as they arrive and strips the carrier from each one with a numerically controlled oscillator that supplies in-phase and quadrature reference levels. Every mixed sample is then correlated against many delayed copies of the local spreading code in the same cycle, one copy per tap. Each tap keeps its own I and Q running sum. Nothing is buffered.

An external code generator supplies the chip stream and a code-clock enable. The tap shift register advances only on that enable. The integration length is a count of valid samples, and a doubling control lets a weak-signal search be repeated with twice the period. When a period ends, each tap latches its sums and its accumulators restart. The channel then finds the tap with the largest I²+Q² and reports it, together with a flag that shows whether it beat the threshold.

Top module: `corr_channel`

## Requirements
- R1: After reset, done_o, hit_o, tap_o and pwr_o are all zero, the carrier phase is zero and every tap chip is 0.
- R2: Sample encoding: bit 1 is the sign and bit 0 the magnitude. 00=+1, 01=+3, 10=-1, 11=-3. The top three phase bits select index p. The cosine level over p=0..7 is 2,1,-1,-2,-2,-1,1,2 and the sine level is 1,2,2,1,-1,-2,-2,-1. Each valid sample adds sample*cos*chip to the I sum of a tap and sample*sin*chip to its Q sum, where chip 0 is +1 and chip 1 is -1. The phase then advances by fcw_i.
- R3: When code_en_i is high, code_i enters tap 0 and tap k takes the old chip of tap k-1. When code_en_i is low, every chip holds. A sample is correlated with the chips held before the shift in that same cycle.
- R4: A period is period_i valid samples, or 2*period_i when double_i is 1. The clock edge that takes the last sample of a period is edge E. done_o is high for one cycle after edge E+1, and the result outputs change only at such edges.
- R5: A cycle with sample_vld_i low adds nothing to any sum, leaves the phase unchanged and does not count toward the period.
- R6: The last sample of a period is included in the latched sums. The accumulators restart from zero at edge E, so the next period holds only its own samples.
- R7: pwr_o is the largest latched I²+Q² over all taps, and tap_o is its index. On a tie the lowest index wins.
- R8: hit_o is 1 only when pwr_o is strictly greater than thresh_i at edge E+1. A power equal to the threshold gives no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | Sample strobe |
| sample_i | input | 2 | Sign/magnitude sample |
| fcw_i | input | PHASE_W | Carrier phase step per valid sample |
| code_en_i | input | 1 | Code-clock pulse that shifts the taps |
| code_i | input | 1 | Next local code chip |
| period_i | input | CNT_W | Valid samples per period (at least 1) |
| double_i | input | 1 | Doubles the period |
| thresh_i | input | PWR_W | Detection threshold |
| done_o | output | 1 | Result strobe |
| hit_o | output | 1 | Peak power above threshold |
| tap_o | output | IDX_W | Index of the peak tap |
| pwr_o | output | PWR_W | Peak I²+Q² |

## Verification
The phase and the tap chips change at the edge that takes a sample or a code pulse. The period sums show up one edge after the closing sample, and the peak result and done_o appear on the edge after that. The bench keeps a model that advances exactly as the RTL should, edge for edge. It samples on the falling edge. After every step it checks that done_o is high exactly when the previous step closed a period, and it then compares tap, power and hit against values the model stored one step earlier. The threshold is chosen in that later step, just below, equal to or just above the expected power, so the strict comparison is exercised at its boundary.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int MIX_W = 4;  // holds +-6

  function automatic logic signed [2:0] sample_lvl(input logic [1:0] s);
    logic signed [2:0] m;
    m = s[0] ? 3'sd3 : 3'sd1;
    return s[1] ? -m : m;
  endfunction

  function automatic logic signed [2:0] cos_lvl(input logic [2:0] p);
    case (p)
      3'd0, 3'd7: return 3'sd2;
      3'd1, 3'd6: return 3'sd1;
      3'd2, 3'd5: return -3'sd1;
      default:    return -3'sd2;
    endcase
  endfunction

  function automatic logic signed [2:0] sin_lvl(input logic [2:0] p);
    case (p)
      3'd1, 3'd2: return 3'sd2;
      3'd0, 3'd3: return 3'sd1;
      3'd4, 3'd7: return -3'sd1;
      default:    return -3'sd2;
    endcase
  endfunction
endpackage

// File: rtl/carrier_nco.sv
module carrier_nco
  import corr_pkg::*;
#(
  parameter int PHASE_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic [PHASE_W-1:0]      fcw_i,
  input  logic [1:0]              sample_i,
  output logic signed [MIX_W-1:0] mix_i_o,
  output logic signed [MIX_W-1:0] mix_q_o,
  output logic [PHASE_W-1:0]      phase_o
);
  logic [PHASE_W-1:0] phase_q;
  logic [2:0] idx;
  logic signed [MIX_W-1:0] sv, cv, snv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else if (vld_i) phase_q <= phase_q + fcw_i;
  end

  assign idx = phase_q[PHASE_W-1 -: 3];
  assign sv  = MIX_W'(sample_lvl(sample_i));
  assign cv  = MIX_W'(cos_lvl(idx));
  assign snv = MIX_W'(sin_lvl(idx));
  assign mix_i_o = sv * cv;
  assign mix_q_o = sv * snv;
  assign phase_o = phase_q;
endmodule

// File: rtl/code_shreg.sv
module code_shreg #(
  parameter int N_TAPS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              code_i,
  output logic [N_TAPS-1:0] chips_o
);
  logic [N_TAPS-1:0] chips_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chips_q <= '0;
    else if (en_i) chips_q <= {chips_q[N_TAPS-2:0], code_i};
  end

  assign chips_o = chips_q;
endmodule

// File: rtl/tap_corr.sv
module tap_corr
  import corr_pkg::*;
#(
  parameter int ACC_W = 20,
  parameter int PWR_W = 2*ACC_W+1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic                    dump_i,
  input  logic                    chip_i,
  input  logic signed [MIX_W-1:0] mix_i_i,
  input  logic signed [MIX_W-1:0] mix_q_i,
  output logic [PWR_W-1:0]        pwr_o
);
  logic signed [ACC_W-1:0] xi, xq, ci, cq, sum_i, sum_q;
  logic signed [ACC_W-1:0] acc_i_q, acc_q_q, lat_i_q, lat_q_q;
  logic signed [PWR_W-1:0] li, lq;

  assign xi = ACC_W'(mix_i_i);
  assign xq = ACC_W'(mix_q_i);
  assign ci = chip_i ? -xi : xi;
  assign cq = chip_i ? -xq : xq;
  assign sum_i = acc_i_q + ci;
  assign sum_q = acc_q_q + cq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_i_q <= '0; acc_q_q <= '0;
      lat_i_q <= '0; lat_q_q <= '0;
    end else if (dump_i) begin
      // closing sample goes into the latch, accumulators restart
      lat_i_q <= sum_i; lat_q_q <= sum_q;
      acc_i_q <= '0;    acc_q_q <= '0;
    end else if (vld_i) begin
      acc_i_q <= sum_i; acc_q_q <= sum_q;
    end
  end

  assign li = PWR_W'(lat_i_q);
  assign lq = PWR_W'(lat_q_q);
  assign pwr_o = PWR_W'(li * li + lq * lq);
endmodule

// File: rtl/peak_sel.sv
module peak_sel #(
  parameter int N_TAPS = 32,
  parameter int PWR_W  = 41,
  parameter int IDX_W  = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         go_i,
  input  logic [N_TAPS-1:0][PWR_W-1:0] pwr_i,
  input  logic [PWR_W-1:0]             thresh_i,
  output logic                         done_o,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             tap_o,
  output logic [PWR_W-1:0]             pwr_o
);
  logic [PWR_W-1:0] best;
  logic [IDX_W-1:0] best_idx;

  // strict compare keeps the lowest index on ties
  always_comb begin
    best = pwr_i[0];
    best_idx = '0;
    for (int k = 1; k < N_TAPS; k++) begin
      if (pwr_i[k] > best) begin
        best = pwr_i[k];
        best_idx = IDX_W'(k);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0; hit_o <= 1'b0; tap_o <= '0; pwr_o <= '0;
    end else begin
      done_o <= go_i;
      if (go_i) begin
        hit_o <= best > thresh_i;
        tap_o <= best_idx;
        pwr_o <= best;
      end
    end
  end
endmodule

// File: rtl/corr_channel.sv
module corr_channel
  import corr_pkg::*;
#(
  parameter int N_TAPS  = 32,
  parameter int ACC_W   = 20,
  parameter int PHASE_W = 32,
  parameter int CNT_W   = 16,
  localparam int PWR_W  = 2*ACC_W+1,
  localparam int IDX_W  = $clog2(N_TAPS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_vld_i,
  input  logic [1:0]         sample_i,
  input  logic [PHASE_W-1:0] fcw_i,
  input  logic               code_en_i,
  input  logic               code_i,
  input  logic [CNT_W-1:0]   period_i,
  input  logic               double_i,
  input  logic [PWR_W-1:0]   thresh_i,
  output logic               done_o,
  output logic               hit_o,
  output logic [IDX_W-1:0]   tap_o,
  output logic [PWR_W-1:0]   pwr_o
);
  logic signed [MIX_W-1:0] mix_i, mix_q;
  logic [PHASE_W-1:0] phase_w;
  logic [N_TAPS-1:0] chips_w;
  logic [N_TAPS-1:0][PWR_W-1:0] pwr_w;
  logic [CNT_W:0] cnt_q, len;
  logic last, dump, dump_q;

  carrier_nco #(.PHASE_W(PHASE_W)) u_nco (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(sample_vld_i), .fcw_i(fcw_i),
    .sample_i(sample_i), .mix_i_o(mix_i), .mix_q_o(mix_q), .phase_o(phase_w)
  );

  code_shreg #(.N_TAPS(N_TAPS)) u_code (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(code_en_i), .code_i(code_i),
    .chips_o(chips_w)
  );

  assign len  = double_i ? {period_i, 1'b0} : {1'b0, period_i};
  assign last = (cnt_q == len - 1'b1);
  assign dump = sample_vld_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; dump_q <= 1'b0;
    end else begin
      dump_q <= dump;
      if (sample_vld_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    tap_corr #(.ACC_W(ACC_W), .PWR_W(PWR_W)) u_tap (
      .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(sample_vld_i), .dump_i(dump),
      .chip_i(chips_w[g]), .mix_i_i(mix_i), .mix_q_i(mix_q), .pwr_o(pwr_w[g])
    );
  end

  peak_sel #(.N_TAPS(N_TAPS), .PWR_W(PWR_W), .IDX_W(IDX_W)) u_peak (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(dump_q), .pwr_i(pwr_w),
    .thresh_i(thresh_i), .done_o(done_o), .hit_o(hit_o), .tap_o(tap_o),
    .pwr_o(pwr_o)
  );
endmodule

// File: rtl/corr_channel_chk.sv
module corr_channel_chk #(
  parameter int N_TAPS  = 32,
  parameter int PHASE_W = 32,
  parameter int PWR_W   = 41,
  parameter int IDX_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sample_vld_i,
  input logic               code_en_i,
  input logic [PWR_W-1:0]   thresh_i,
  input logic               done_o,
  input logic               hit_o,
  input logic [IDX_W-1:0]   tap_o,
  input logic [PWR_W-1:0]   pwr_o,
  input logic [PHASE_W-1:0] phase_i,
  input logic [N_TAPS-1:0]  chips_i
);
  assert_tap_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (32'(tap_o) < N_TAPS));

  assert_hit_above_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o) |-> (pwr_o > $past(thresh_i)));

  assert_miss_below_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (pwr_o <= $past(thresh_i)));

  assert_result_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(pwr_o) && $stable(tap_o) && $stable(hit_o)));

  assert_phase_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> $stable(phase_i));

  assert_code_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_en_i |=> $stable(chips_i));
endmodule

bind corr_channel corr_channel_chk #(
  .N_TAPS(N_TAPS), .PHASE_W(PHASE_W), .PWR_W(PWR_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sample_vld_i(sample_vld_i),
  .code_en_i(code_en_i), .thresh_i(thresh_i), .done_o(done_o), .hit_o(hit_o),
  .tap_o(tap_o), .pwr_o(pwr_o), .phase_i(phase_w), .chips_i(chips_w)
);

// File: tb/corr_channel_tb_top.sv
module corr_channel_tb_top;
  localparam int N = 32;
  localparam int PW = 41;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_vld_i = 1'b0;
  logic [1:0] sample_i = '0;
  logic [31:0] fcw_i = '0;
  logic code_en_i = 1'b0, code_i = 1'b0;
  logic [15:0] period_i = 16'd1;
  logic double_i = 1'b0;
  logic [PW-1:0] thresh_i = '0;
  logic done_o, hit_o;
  logic [4:0] tap_o;
  logic [PW-1:0] pwr_o;

  always #5 clk = ~clk;

  corr_channel dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sample_vld_i(sample_vld_i), .sample_i(sample_i),
    .fcw_i(fcw_i), .code_en_i(code_en_i), .code_i(code_i), .period_i(period_i),
    .double_i(double_i), .thresh_i(thresh_i), .done_o(done_o), .hit_o(hit_o),
    .tap_o(tap_o), .pwr_o(pwr_o)
  );

  int n_chk = 0, n_bad = 0;
  int chip_m [N];
  longint ai [N], aq [N];
  logic [31:0] ph = '0;
  int cnt = 0;
  bit dump_last = 0, thr_mode = 0;
  int p_tap = 0;
  longint p_pwr = 0;

  function automatic int lvl_s(logic [1:0] s);
    int m = s[0] ? 3 : 1;
    return s[1] ? -m : m;
  endfunction
  function automatic int lvl_c(logic [2:0] p);
    case (p) 0, 7: return 2; 1, 6: return 1; 2, 5: return -1; default: return -2; endcase
  endfunction
  function automatic int lvl_n(logic [2:0] p);
    case (p) 1, 2: return 2; 0, 3: return 1; 4, 7: return -1; default: return -2; endcase
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [1:0] s, bit ce, bit c);
    bit was = dump_last, now = 0;
    int c_tap = p_tap;
    longint c_pwr = p_pwr;
    if (was && thr_mode) begin
      longint t = c_pwr + longint'($urandom % 3) - 1;
      thresh_i = PW'((t < 0) ? 0 : t);
    end
    sample_vld_i = v; sample_i = s; code_en_i = ce; code_i = c;
    if (v) begin
      int sv = lvl_s(s), cv = lvl_c(ph[31:29]), nv = lvl_n(ph[31:29]);
      int len = double_i ? 2 * int'(period_i) : int'(period_i);
      for (int k = 0; k < N; k++) begin
        int m = chip_m[k] ? -1 : 1;
        ai[k] += sv * cv * m;
        aq[k] += sv * nv * m;
      end
      ph = ph + fcw_i;
      if (cnt == len - 1) begin
        now = 1; p_tap = 0; p_pwr = ai[0] * ai[0] + aq[0] * aq[0];
        for (int k = 1; k < N; k++) begin
          longint pw = ai[k] * ai[k] + aq[k] * aq[k];
          if (pw > p_pwr) begin p_pwr = pw; p_tap = k; end
        end
        for (int k = 0; k < N; k++) begin ai[k] = 0; aq[k] = 0; end
        cnt = 0;
      end else cnt++;
    end
    if (ce) begin
      for (int k = N - 1; k > 0; k--) chip_m[k] = chip_m[k-1];
      chip_m[0] = c;
    end
    @(posedge clk); @(negedge clk);
    check("R4 done", longint'(done_o), longint'(was));
    if (was) begin
      check("R7 tap", longint'(tap_o), longint'(c_tap));
      check("R2 R3 R5 R6 power", longint'(pwr_o), c_pwr);
      check("R8 hit", longint'(hit_o), longint'(c_pwr > longint'(thresh_i)));
    end
    dump_last = now;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed = $urandom(32'd4711);
    for (int k = 0; k < N; k++) begin chip_m[k] = 0; ai[k] = 0; aq[k] = 0; end
    seed = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", longint'(done_o), 0);
    check("R1 hit", longint'(hit_o), 0);
    check("R1 tap", longint'(tap_o), 0);
    check("R1 pwr", longint'(pwr_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 R7 R8: one +1 sample at phase 0, all chips 0 -> I=2 Q=1, power 5 on every tap
    thresh_i = PW'(5);
    step(1, 2'b00, 0, 0);
    step(0, 2'b00, 0, 0);
    check("R8 equal threshold no hit", longint'(hit_o), 0);
    check("R7 tie lowest index", longint'(tap_o), 0);
    thresh_i = PW'(4);
    step(1, 2'b00, 0, 0);
    step(0, 2'b00, 0, 0);
    check("R8 above threshold hit", longint'(hit_o), 1);

    // R3: load a pattern with no samples, then idle code clock with toggling code_i
    for (int k = 0; k < N; k++) step(0, 2'b11, 1, 1'((k * 7 + 3) % 5 == 0));
    period_i = 16'd4; fcw_i = 32'h2000_0000;
    for (int k = 0; k < 8; k++) step(1, 2'(k), 0, 1'(k));
    // R5: invalid samples between valid ones
    for (int k = 0; k < 12; k++) step(k % 3 == 0, 2'b01, 0, 1);
    step(0, 2'b00, 0, 0);

    // R4 R6: doubled period, then random traffic
    thr_mode = 1;
    period_i = 16'd3; double_i = 1'b1;
    for (int k = 0; k < 8; k++) step(1, 2'b10, 0, 0);
    for (int k = 0; k < 6000; k++) begin
      if (dump_last || cnt == 0) begin
        period_i = 16'(1 + $urandom % 20);
        double_i = 1'($urandom % 2);
        fcw_i = $urandom;
      end
      step(($urandom % 4) != 0, 2'($urandom), ($urandom % 10) < 3, 1'($urandom));
    end
    step(0, 2'b00, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule